// File: doc/BRIEF.md
# CDR Lock Mode Controller

This block chooses what a clock-data-recovery loop tracks: the reference clock or the incoming serial stream. It also sequences the reset of the receiver's digital logic. In automatic operation it starts on the reference clock. It hands over to the data only after the signal-present, frequency-match and phase-match flags have all been true together for a qualifying run of cycles. If that agreement is lost, it falls back to the reference. Two override inputs can pin the loop to either source, and the data override takes priority.

Downstream logic is held in reset until the controller has reported lock to data, without a break, for a fixed minimum time. That time is given in nanoseconds and converted to cycles from the clock frequency parameter. All detector and override inputs are asynchronous to the controller clock and pass through synchronizer stages before use.

Top module: `cdr_lock_ctrl`

## Requirements
- R1: After reset, `lock_to_data_o`=0, `locked_to_data_o`=0 and `rx_dig_rst_o`=1. The block is in automatic reference tracking.
- R2: With both overrides low, `lock_to_data_o` rises only after `sig_det_i`, `freq_lock_i` and `phase_lock_i` have all been 1 for QUAL_CYCLES (default 4) consecutive synchronized cycles. A run of QUAL_CYCLES-1 cycles causes no handover.
- R3: If any one of the three detector flags is 0, automatic mode keeps tracking the reference (`lock_to_data_o`=0).
- R4: In automatic data tracking, losing any detector flag returns the block to reference tracking. `lock_to_data_o` and `locked_to_data_o` both go to 0.
- R5: With `force_ref_i`=1 and `force_data_i`=0, `lock_to_data_o` stays 0 whatever the detector flags are.
- R6: With `force_data_i`=1, `lock_to_data_o`=1 regardless of `force_ref_i` and the detector flags.
- R7: In forced data mode, entered from reference tracking, `locked_to_data_o` is 0 for the first SETTLE_CYCLES (default 8) cycles after `lock_to_data_o` rises. It becomes 1 exactly SETTLE_CYCLES cycles after the rise.
- R8: In automatic mode, `locked_to_data_o` equals `lock_to_data_o`.
- R9: `rx_dig_rst_o` stays 1 until `locked_to_data_o` has been 1 continuously for HOLD_CYCLES = ceil(HOLD_NS × CLK_FREQ_HZ / 1e9) cycles (200 by default), and it falls exactly then.
- R10: When `locked_to_data_o` falls, `rx_dig_rst_o` returns to 1 one cycle later. The hold count restarts from zero.
- R11: When both overrides are released while the detector flags are low, the block returns to automatic reference tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock of frequency CLK_FREQ_HZ |
| arst_n | input | 1 | Asynchronous active-low reset |
| sig_det_i | input | 1 | Valid signal level present at receiver input (async) |
| freq_lock_i | input | 1 | Recovered clock within ppm threshold of reference (async) |
| phase_lock_i | input | 1 | Recovered clock phase-aligned to reference (async) |
| force_ref_i | input | 1 | Manual override: pin loop to reference clock (async) |
| force_data_i | input | 1 | Manual override: pin loop to data; wins over force_ref_i (async) |
| lock_to_data_o | output | 1 | 1 selects data tracking, 0 selects reference tracking |
| locked_to_data_o | output | 1 | Status: loop considered locked to data |
| rx_dig_rst_o | output | 1 | Reset for receiver digital logic, active high |

## Verification
The bench probes the qualification boundary directly. A run one cycle short of QUAL_CYCLES must not hand over, and a full run must. A filter that was off by one, or that did not require all three flags together, would switch to data on a glitch. It counts cycles from the lock rise to the reset release, and from the rise of the data select to the manual settle flag, so a counter that releases one cycle early or late is caught. It also checks that reset comes back one cycle after lock is lost. Randomly held input combinations, including both overrides set together, check the priority of the data override and the steady-state outputs against a function of the inputs alone.

// File: rtl/cdr_lock_pkg.sv
package cdr_lock_pkg;
   typedef enum logic [1:0] {
      ST_AUTO_REF  = 2'd0,
      ST_AUTO_DATA = 2'd1,
      ST_MAN_REF   = 2'd2,
      ST_MAN_DATA  = 2'd3
   } cdr_state_e;

   function automatic int ns_to_cycles(input longint ns, input longint hz);
      return int'((ns * hz + 64'd999_999_999) / 64'd1_000_000_000);
   endfunction
endpackage

// File: rtl/cdr_sync.sv
module cdr_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cdr_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) begin
            stage_q[s] <= '0;
         end else begin
            if (s == 0) stage_q[s] <= async_i;
            else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cdr_lock_fsm.sv
module cdr_lock_fsm
   import cdr_lock_pkg::*;
#(
   parameter int QUAL_CYCLES   = 4,
   parameter int SETTLE_CYCLES = 8
) (
   input  logic clk,
   input  logic arst_n,
   input  logic sd_i,
   input  logic fl_i,
   input  logic pl_i,
   input  logic fr_i,
   input  logic fd_i,
   output logic ltd_o,
   output logic locked_o
);
   localparam int QW = $clog2(QUAL_CYCLES + 1);

   if (QUAL_CYCLES < 1) begin : g_bad_qual
      $error("cdr_lock_fsm: QUAL_CYCLES must be at least 1");
   end
   if (SETTLE_CYCLES < 0) begin : g_bad_settle
      $error("cdr_lock_fsm: SETTLE_CYCLES must not be negative");
   end

   cdr_state_e st_q, st_d;
   logic [QW-1:0] qual_q;
   logic          all_ok, qual_done, settled;

   assign all_ok    = sd_i & fl_i & pl_i;
   assign qual_done = all_ok && (qual_q == QW'(QUAL_CYCLES - 1));

   always_comb begin
      st_d = st_q;
      if (fd_i) begin
         st_d = ST_MAN_DATA;
      end else if (fr_i) begin
         st_d = ST_MAN_REF;
      end else begin
         unique case (st_q)
            ST_AUTO_REF:  st_d = qual_done ? ST_AUTO_DATA : ST_AUTO_REF;
            ST_AUTO_DATA: st_d = all_ok ? ST_AUTO_DATA : ST_AUTO_REF;
            default:      st_d = ST_AUTO_REF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         st_q   <= ST_AUTO_REF;
         qual_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_AUTO_REF && all_ok && !fd_i && !fr_i && !qual_done)
            qual_q <= qual_q + QW'(1);
         else
            qual_q <= '0;
      end
   end

   if (SETTLE_CYCLES == 0) begin : g_no_settle
      assign settled = 1'b1;
   end else begin : g_settle
      localparam int SW = $clog2(SETTLE_CYCLES + 1);
      logic [SW-1:0] settle_q;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n)
            settle_q <= '0;
         else if (st_q != ST_MAN_DATA)
            settle_q <= '0;
         else if (settle_q != SW'(SETTLE_CYCLES))
            settle_q <= settle_q + SW'(1);
      end
      assign settled = (settle_q == SW'(SETTLE_CYCLES));
   end

   assign ltd_o    = (st_q == ST_AUTO_DATA) || (st_q == ST_MAN_DATA);
   assign locked_o = (st_q == ST_AUTO_DATA) || ((st_q == ST_MAN_DATA) && settled);

   // R6
   man_data_chk: assert property (@(posedge clk) disable iff (!arst_n)
      fd_i |=> (st_q == ST_MAN_DATA));

   // R5
   man_ref_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (fr_i && !fd_i) |=> (st_q == ST_MAN_REF));

   // R2
   handover_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (st_q == ST_AUTO_DATA && $past(st_q) == ST_AUTO_REF) |-> $past(all_ok));

   // R4
   fallback_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (st_q == ST_AUTO_DATA && !all_ok && !fd_i && !fr_i) |=> (st_q == ST_AUTO_REF));
endmodule

// File: rtl/cdr_rst_hold.sv
module cdr_rst_hold #(
   parameter int HOLD_CYCLES = 200
) (
   input  logic clk,
   input  logic arst_n,
   input  logic locked_i,
   output logic rst_o
);
   localparam int HW = $clog2(HOLD_CYCLES + 1);

   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("cdr_rst_hold: HOLD_CYCLES must be at least 1");
   end

   logic [HW-1:0] hold_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)
         hold_q <= '0;
      else if (!locked_i)
         hold_q <= '0;
      else if (hold_q != HW'(HOLD_CYCLES))
         hold_q <= hold_q + HW'(1);
   end

   assign rst_o = (hold_q != HW'(HOLD_CYCLES));

   // R10
   rearm_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !locked_i |=> rst_o);

   // R9
   release_chk: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(rst_o) |-> $past(locked_i));

   // R9
   hold_bound_chk: assert property (@(posedge clk) disable iff (!arst_n)
      hold_q <= HW'(HOLD_CYCLES));
endmodule

// File: rtl/cdr_lock_ctrl.sv
module cdr_lock_ctrl
   import cdr_lock_pkg::*;
#(
   parameter int CLK_FREQ_HZ   = 50_000_000,
   parameter int HOLD_NS       = 4000,
   parameter int SYNC_STAGES   = 2,
   parameter int QUAL_CYCLES   = 4,
   parameter int SETTLE_CYCLES = 8
) (
   input  logic clk,
   input  logic arst_n,
   input  logic sig_det_i,
   input  logic freq_lock_i,
   input  logic phase_lock_i,
   input  logic force_ref_i,
   input  logic force_data_i,
   output logic lock_to_data_o,
   output logic locked_to_data_o,
   output logic rx_dig_rst_o
);
   localparam int HOLD_CYCLES = ns_to_cycles(longint'(HOLD_NS), longint'(CLK_FREQ_HZ));
   localparam int NIN = 5;

   if (CLK_FREQ_HZ < 1 || HOLD_NS < 1) begin : g_bad_time
      $error("cdr_lock_ctrl: CLK_FREQ_HZ and HOLD_NS must be positive");
   end

   logic [NIN-1:0] raw, syn;
   logic           locked;

   assign raw = {force_data_i, force_ref_i, phase_lock_i, freq_lock_i, sig_det_i};

   cdr_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .async_i(raw),
      .sync_o (syn)
   );

   cdr_lock_fsm #(.QUAL_CYCLES(QUAL_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
      .clk     (clk),
      .arst_n  (arst_n),
      .sd_i    (syn[0]),
      .fl_i    (syn[1]),
      .pl_i    (syn[2]),
      .fr_i    (syn[3]),
      .fd_i    (syn[4]),
      .ltd_o   (lock_to_data_o),
      .locked_o(locked)
   );

   cdr_rst_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk     (clk),
      .arst_n  (arst_n),
      .locked_i(locked),
      .rst_o   (rx_dig_rst_o)
   );

   assign locked_to_data_o = locked;
endmodule

// File: tb/cdr_lock_ctrl_bench.sv
module cdr_lock_ctrl_bench;
   localparam int QUAL   = 4;
   localparam int SETTLE = 8;
   localparam int HOLD   = 200;

   logic clk = 1'b0;
   logic arst_n = 1'b0;
   logic sd = 0, fl = 0, pl = 0, fr = 0, fd = 0;
   logic ltd, locked, rst;
   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   cdr_lock_ctrl u_cdr_lock_ctrl (
      .clk(clk), .arst_n(arst_n),
      .sig_det_i(sd), .freq_lock_i(fl), .phase_lock_i(pl),
      .force_ref_i(fr), .force_data_i(fd),
      .lock_to_data_o(ltd), .locked_to_data_o(locked), .rx_dig_rst_o(rst)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic exp_ltd(logic f_d, logic f_r, logic s, logic f, logic p);
      return f_d | (!f_r & s & f & p);
   endfunction

   task automatic watch_ltd(input int n, output logic seen);
      seen = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (ltd === 1'b1) seen = 1'b1;
      end
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic seen;
      int   n;
      void'($urandom(32'd1234));
      step(3);
      // R1 reset state
      check("R1 ltd", ltd, 1'b0);
      check("R1 locked", locked, 1'b0);
      check("R1 rst", rst, 1'b1);
      arst_n = 1'b1;
      step(3);
      check("R1 ltd after release", ltd, 1'b0);

      // R3 one flag missing
      sd = 0; fl = 1; pl = 1;
      watch_ltd(20, seen);
      check("R3 no signal detect", seen, 1'b0);
      sd = 1; fl = 0; pl = 1;
      watch_ltd(20, seen);
      check("R3 no freq lock", seen, 1'b0);
      sd = 1; fl = 1; pl = 0;
      watch_ltd(20, seen);
      check("R3 no phase lock", seen, 1'b0);

      // R2 qualification boundary
      pl = 1; step(QUAL - 1); pl = 0;
      watch_ltd(12, seen);
      check("R2 short run", seen, 1'b0);
      pl = 1; step(QUAL); pl = 0;
      watch_ltd(12, seen);
      check("R2 full run", seen, 1'b1);
      check("R4 back to ref", ltd, 1'b0);

      // R9 hold release timing
      pl = 1;
      n = 0;
      while (locked !== 1'b1 && n < 50) begin step(1); n++; end
      check("R8 locked with ltd", locked, ltd);
      check("R9 rst at lock rise", rst, 1'b1);
      step(HOLD - 1);
      check("R9 rst one cycle early", rst, 1'b1);
      step(1);
      check("R9 rst released", rst, 1'b0);

      // R4 and R10 loss of signal
      sd = 0;
      n = 0;
      while (locked !== 1'b0 && n < 50) begin step(1); n++; end
      check("R4 ltd dropped", ltd, 1'b0);
      check("R10 rst at fall", rst, 1'b0);
      step(1);
      check("R10 rst reasserted", rst, 1'b1);

      // R5 forced reference
      fr = 1; step(6);
      sd = 1; fl = 1; pl = 1;
      watch_ltd(30, seen);
      check("R5 forced ref", seen, 1'b0);

      // R6 and R7 forced data with both overrides set
      fd = 1;
      n = 0;
      while (ltd !== 1'b1 && n < 50) begin step(1); n++; end
      check("R6 fd wins", ltd, 1'b1);
      check("R7 locked at entry", locked, 1'b0);
      step(SETTLE - 1);
      check("R7 locked one early", locked, 1'b0);
      step(1);
      check("R7 locked settled", locked, 1'b1);

      // R11 release overrides
      sd = 0; fl = 0; pl = 0;
      fd = 0; fr = 0;
      step(8);
      check("R11 auto ref ltd", ltd, 1'b0);
      check("R11 auto ref locked", locked, 1'b0);

      // random held patterns
      for (int k = 0; k < 80; k++) begin
         logic e;
         fd = ($urandom % 4) == 0;
         fr = ($urandom % 4) == 0;
         sd = ($urandom % 5) != 0;
         fl = ($urandom % 5) != 0;
         pl = ($urandom % 5) != 0;
         step(30);
         e = exp_ltd(fd, fr, sd, fl, pl);
         check(fd ? "R6 random ltd" : (fr ? "R5 random ltd" : "R2 random ltd"), ltd, e);
         check(fd ? "R7 random locked" : "R8 random locked", locked, e);
         if (!e) check("R9 random rst", rst, 1'b1);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule